// File: doc/BRIEF.md
# Burst-Mode Flash Read Sequencer

This block is the read-side control of a 16-bit flash array that serves either plain asynchronous reads or clocked burst reads. A command decoder watches bus writes for two four-write unlock sequences, one that turns burst mode on and one that turns it off. Only a hardware reset also clears the mode. A single-write soft-reset command only clears a half-finished sequence in the decoder.

In burst mode a host pulses a load-address strobe to latch a start address. After a fixed initial latency the first word appears. From then on every clock edge with the advance strobe low moves to the next word. The address wraps inside a 32-word aligned window. An active-low marker goes low while the 32nd word is on the bus. Advancing past that word ends the burst. The array itself sits outside the block as a synchronous memory. The block gives it a look-ahead address, so the read data always belongs to the current word.

Top module: `burst_flash_seq`

## Requirements
- R1: While and after `rst_n` is low, `burst_mode` is 0 and `last_n` is 1. With `ce_n` high, `dout_valid` is 0 and `dout` is 0.
- R2: In non-burst mode with `ce_n` and `oe_n` low, `dout_valid` is 1 and `dout` equals the array word at the `addr_in` value sampled at the last clock edge. `load_n` has no effect in this mode.
- R3: Four writes in order set `burst_mode` at the edge of the fourth write: 0x00AA at 0x555, 0x0055 at 0x2AA, 0x0078 at 0x555, then 0x00A5 at 0x555. The same sequence with 0x005A as its fourth data clears `burst_mode`.
- R4: A write that does not match the next expected pair returns the decoder to its first step and leaves `burst_mode` unchanged. An incomplete sequence never changes the mode.
- R5: A write of data 0x00F0 at any address leaves `burst_mode` unchanged and restarts the decoder. Driving `rst_n` low clears `burst_mode`.
- R6: In burst mode, an edge with `ce_n` and `load_n` low latches `addr_in`. If `load_n` is still low at the following edge, the address is latched again. The first word becomes valid INIT_LAT (default 3) edges after the last load edge, with `dout_valid` 0 until then. Later changes of `addr_in` have no effect on the burst.
- R7: Once the first word is out, each edge with `adv_n` low presents the next word. Only the low 5 address bits count, wrapping within the 32-word window. The upper bits stay fixed.
- R8: Once the first word is out, an edge with `adv_n` high holds the address and the output word.
- R9: `last_n` is 0 exactly while the 32nd word of a burst is valid on `dout`, and 1 otherwise. An edge with `adv_n` low on that word ends the burst, and `dout_valid` goes 0.
- R10: With `ce_n` or `oe_n` high, `dout_valid` is 0 and `dout` is 0. The burst position is kept, and `load_n` is ignored while `ce_n` is high.
- R11: A load during a burst in progress aborts it. The new burst starts with its own latency from the new address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Burst clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| wr_en | input | 1 | Bus write strobe, one per written word |
| wr_addr | input | ADDR_W | Bus write address |
| wr_data | input | DATA_W | Bus write data |
| load_n | input | 1 | Active-low burst address load strobe |
| adv_n | input | 1 | Active-low burst advance strobe |
| addr_in | input | ADDR_W | Read address |
| mem_addr | output | ADDR_W | Look-ahead address to the synchronous array |
| mem_rdata | input | DATA_W | Array word, one cycle after `mem_addr` |
| dout | output | DATA_W | Read data, 0 when not valid |
| dout_valid | output | 1 | Data bus driven (low models high impedance) |
| last_n | output | 1 | Active-low last-word-of-burst marker |
| burst_mode | output | 1 | Burst mode flag |

## Verification
The main read path is tried with asynchronous reads at the lowest, highest and a mixed address. It is also tried with bursts that start mid-window, so that the wrap from word 31 to word 0 separates windowed counting from linear counting. Bursts with held advance strobes and with a double load strobe separate a stalled burst and a reloaded start from a free-running counter. Command sequences broken at the second step, by a wrong address or by a soft reset are set against complete ones. This shows that only the full ordered sequence changes the mode and that hardware reset alone also clears it.

// File: rtl/burst_flash_pkg.sv
// Package: types shared by the burst read sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package burst_flash_pkg;

    // Burst engine phases: idle, address just latched, latency wait, data out.
    typedef enum logic [1:0] {
        BST_IDLE = 2'd0,
        BST_LOAD = 2'd1,
        BST_WAIT = 2'd2,
        BST_DATA = 2'd3
    } bst_state_e;

    // Position inside a four-write unlock sequence.
    typedef enum logic [1:0] {
        CST_STEP0 = 2'd0,
        CST_STEP1 = 2'd1,
        CST_STEP2 = 2'd2,
        CST_STEP3 = 2'd3
    } cmd_step_e;

endpackage

// File: rtl/bfs_cmd_decoder.sv
// Module: bfs_cmd_decoder
// Follows the four-write unlock sequences and keeps the burst-mode flag.
// Assumes: one wr_stb pulse per bus write; a soft-reset data word
// restarts the sequence at any step without touching the flag.
module bfs_cmd_decoder
    import burst_flash_pkg::*;
#(
    parameter int                  AW          = 19,
    parameter int                  DW          = 16,
    parameter logic [AW-1:0]       ADDR1       = 'h555,
    parameter logic [AW-1:0]       ADDR2       = 'h2AA,
    parameter logic [DW-1:0]       KEY1        = 'hAA,
    parameter logic [DW-1:0]       KEY2        = 'h55,
    parameter logic [DW-1:0]       KEY3        = 'h78,
    parameter logic [DW-1:0]       ENABLE_CODE = 'hA5,
    parameter logic [DW-1:0]       DISABLE_CODE= 'h5A,
    parameter logic [DW-1:0]       SWRESET_CODE= 'hF0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stb,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic          mode
);

    cmd_step_e step_q, step_d;
    logic      mode_d;

    // Next step and next flag from the current write.
    always_comb begin
        step_d = step_q;
        mode_d = mode;
        if (wr_stb) begin
            step_d = CST_STEP0;
            if (wr_data != SWRESET_CODE) begin
                case (step_q)
                    CST_STEP0: if (wr_addr == ADDR1 && wr_data == KEY1) step_d = CST_STEP1;
                    CST_STEP1: if (wr_addr == ADDR2 && wr_data == KEY2) step_d = CST_STEP2;
                    CST_STEP2: if (wr_addr == ADDR1 && wr_data == KEY3) step_d = CST_STEP3;
                    CST_STEP3: begin
                        if (wr_addr == ADDR1 && wr_data == ENABLE_CODE)  mode_d = 1'b1;
                        if (wr_addr == ADDR1 && wr_data == DISABLE_CODE) mode_d = 1'b0;
                    end
                    default: step_d = CST_STEP0;
                endcase
            end
        end
    end

    // Sequence and flag registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            step_q <= CST_STEP0;
            mode   <= 1'b0;
        end else begin
            step_q <= step_d;
            mode   <= mode_d;
        end
    end

endmodule

// File: rtl/bfs_burst_engine.sv
// Module: bfs_burst_engine
// Latches the burst start, counts the initial latency, steps the word
// address inside its aligned window and counts delivered words.
// Assumes: LAT >= 2; the array reads mem_addr synchronously, so the
// look-ahead (next) address is sent to keep data aligned with a_q.
module bfs_burst_engine
    import burst_flash_pkg::*;
#(
    parameter int AW    = 19,
    parameter int WIN_W = 5,
    parameter int LAT   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode,
    input  logic          ce_n,
    input  logic          load_n,
    input  logic          adv_n,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] mem_addr,
    output logic [AW-1:0] a_q,
    output bst_state_e    st_q,
    output logic          word_last
);

    localparam int             CW     = $clog2(LAT) + 1;
    localparam logic [CW-1:0]  CNT_LD = CW'(LAT - 2);
    localparam logic [WIN_W-1:0] W_LAST = '1;

    bst_state_e         st_d;
    logic [AW-1:0]      a_d;
    logic [CW-1:0]      cnt_q, cnt_d;
    logic [WIN_W-1:0]   w_q, w_d;
    logic               load_hit;

    assign load_hit = mode && !ce_n && !load_n;

    // Next state, address, latency count and word count.
    always_comb begin
        st_d  = st_q;
        a_d   = a_q;
        cnt_d = cnt_q;
        w_d   = w_q;
        if (!mode) begin
            st_d = BST_IDLE;
            a_d  = addr_in;
        end else if (load_hit) begin
            st_d = BST_LOAD;
            a_d  = addr_in;
            w_d  = '0;
        end else begin
            case (st_q)
                BST_LOAD: begin
                    st_d  = BST_WAIT;
                    cnt_d = CNT_LD;
                end
                BST_WAIT: begin
                    if (cnt_q == '0) st_d = BST_DATA;
                    else             cnt_d = cnt_q - 1'b1;
                end
                BST_DATA: begin
                    if (!adv_n) begin
                        if (w_q == W_LAST) begin
                            st_d = BST_IDLE;
                        end else begin
                            w_d = w_q + 1'b1;
                            a_d = {a_q[AW-1:WIN_W], WIN_W'(a_q[WIN_W-1:0] + 1'b1)};
                        end
                    end
                end
                default: st_d = BST_IDLE;
            endcase
        end
    end

    // Engine registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= BST_IDLE;
            a_q   <= '0;
            cnt_q <= '0;
            w_q   <= '0;
        end else begin
            st_q  <= st_d;
            a_q   <= a_d;
            cnt_q <= cnt_d;
            w_q   <= w_d;
        end
    end

    assign mem_addr  = a_d;
    assign word_last = (st_q == BST_DATA) && (w_q == W_LAST);

endmodule

// File: rtl/bfs_out_stage.sv
// Module: bfs_out_stage
// Gates array data onto the output bus and forms the last-word marker.
// Assumes: a valid flag stands for a driven bus; invalid data is zero.
module bfs_out_stage
    import burst_flash_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          mode,
    input  bst_state_e    st_q,
    input  logic          word_last,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] dout,
    output logic          dout_valid,
    output logic          last_n
);

    logic bus_on;

    // Drive the bus only when enabled and a word is ready.
    always_comb begin
        bus_on     = !ce_n && !oe_n;
        dout_valid = bus_on && (!mode || st_q == BST_DATA);
        dout       = dout_valid ? mem_rdata : '0;
        last_n     = !(dout_valid && mode && word_last);
    end

endmodule

// File: rtl/burst_flash_seq.sv
// Module: burst_flash_seq (top)
// Read sequencer for a flash array with asynchronous and burst reads.
// Assumes: synchronous array outside, one-cycle read latency on mem_addr.
module burst_flash_seq
    import burst_flash_pkg::*;
#(
    parameter int                      ADDR_W       = 19,
    parameter int                      DATA_W       = 16,
    parameter int                      BURST_LOG2   = 5,
    parameter int                      INIT_LAT     = 3,
    parameter logic [ADDR_W-1:0]       CMD_ADDR1    = 'h555,
    parameter logic [ADDR_W-1:0]       CMD_ADDR2    = 'h2AA,
    parameter logic [DATA_W-1:0]       CMD_KEY1     = 'hAA,
    parameter logic [DATA_W-1:0]       CMD_KEY2     = 'h55,
    parameter logic [DATA_W-1:0]       CMD_KEY3     = 'h78,
    parameter logic [DATA_W-1:0]       CMD_ENABLE   = 'hA5,
    parameter logic [DATA_W-1:0]       CMD_DISABLE  = 'h5A,
    parameter logic [DATA_W-1:0]       CMD_SWRESET  = 'hF0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              load_n,
    input  logic              adv_n,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] dout,
    output logic              dout_valid,
    output logic              last_n,
    output logic              burst_mode
);

    logic              wr_stb;
    logic [ADDR_W-1:0] a_q;
    bst_state_e        st_q;
    logic              word_last;

    assign wr_stb = wr_en && !ce_n;

    bfs_cmd_decoder #(
        .AW(ADDR_W), .DW(DATA_W),
        .ADDR1(CMD_ADDR1), .ADDR2(CMD_ADDR2),
        .KEY1(CMD_KEY1), .KEY2(CMD_KEY2), .KEY3(CMD_KEY3),
        .ENABLE_CODE(CMD_ENABLE), .DISABLE_CODE(CMD_DISABLE),
        .SWRESET_CODE(CMD_SWRESET)
    ) i_dec (
        .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb),
        .wr_addr(wr_addr), .wr_data(wr_data), .mode(burst_mode)
    );

    bfs_burst_engine #(
        .AW(ADDR_W), .WIN_W(BURST_LOG2), .LAT(INIT_LAT)
    ) i_eng (
        .clk(clk), .rst_n(rst_n), .mode(burst_mode), .ce_n(ce_n),
        .load_n(load_n), .adv_n(adv_n), .addr_in(addr_in),
        .mem_addr(mem_addr), .a_q(a_q), .st_q(st_q), .word_last(word_last)
    );

    bfs_out_stage #(
        .DW(DATA_W)
    ) i_out (
        .mode(burst_mode), .st_q(st_q), .word_last(word_last),
        .ce_n(ce_n), .oe_n(oe_n), .mem_rdata(mem_rdata),
        .dout(dout), .dout_valid(dout_valid), .last_n(last_n)
    );

endmodule

// File: rtl/bfs_checker.sv
// Module: bfs_checker
// Protocol properties of the burst read sequencer, bound to the top.
module bfs_checker
    import burst_flash_pkg::*;
#(
    parameter int                AW     = 19,
    parameter int                DW     = 16,
    parameter int                WIN_W  = 5,
    parameter logic [DW-1:0]     EN_CODE = 'hA5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ce_n,
    input logic          oe_n,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          load_n,
    input logic          adv_n,
    input logic          dout_valid,
    input logic          last_n,
    input logic          burst_mode,
    input logic [AW-1:0] a_q,
    input bst_state_e    st_q
);

    // R10: a disabled bus is never driven.
    assert_bus_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || oe_n) |-> !dout_valid);

    // R9: the last-word marker only appears on a driven word.
    assert_last_on_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !last_n |-> dout_valid);

    // R3: burst mode only turns on after the enable code was written.
    assert_mode_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(burst_mode) |-> $past(wr_en && !ce_n && wr_data == EN_CODE));

    // R8: a held advance strobe keeps the word address.
    assert_hold_addr_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && st_q == BST_DATA && adv_n && (load_n || ce_n) && !wr_en)
        |=> $stable(a_q));

    // R7: an advance moves only the in-window bits, by one.
    assert_step_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_mode && st_q == BST_DATA && !adv_n && (load_n || ce_n) && !wr_en && last_n)
        |=> (a_q[WIN_W-1:0] == WIN_W'($past(a_q[WIN_W-1:0]) + 1'b1))
            && (a_q[AW-1:WIN_W] == $past(a_q[AW-1:WIN_W])));

endmodule

bind burst_flash_seq bfs_checker #(
    .AW(ADDR_W), .DW(DATA_W), .WIN_W(BURST_LOG2), .EN_CODE(CMD_ENABLE)
) i_bfs_checker (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_en(wr_en),
    .wr_data(wr_data), .load_n(load_n), .adv_n(adv_n),
    .dout_valid(dout_valid), .last_n(last_n), .burst_mode(burst_mode),
    .a_q(a_q), .st_q(st_q)
);

// File: tb/test_burst_flash_seq.sv
// Scoreboard bench: driver tasks queue expected results per clock edge,
// the monitor pops and compares them shortly after each rising edge.
module test_burst_flash_seq;

    localparam int AW  = 19;
    localparam int DW  = 16;
    localparam int LAT = 3;
    localparam logic [AW-1:0] A1 = 19'h555;
    localparam logic [AW-1:0] A2 = 19'h2AA;
    localparam logic [DW-1:0] K1 = 16'h00AA;
    localparam logic [DW-1:0] K2 = 16'h0055;
    localparam logic [DW-1:0] K3 = 16'h0078;
    localparam logic [DW-1:0] KEN = 16'h00A5;
    localparam logic [DW-1:0] KDIS = 16'h005A;
    localparam logic [DW-1:0] KSW = 16'h00F0;

    logic clk = 1'b0;
    logic rst_n, ce_n, oe_n, wr_en, load_n, adv_n;
    logic [AW-1:0] wr_addr, addr_in, mem_addr;
    logic [DW-1:0] wr_data, mem_rdata, dout;
    logic dout_valid, last_n, burst_mode;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          tgt;
        logic        v;
        logic [DW-1:0] d;
        logic        l;
        logic        m;
        string       req;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    burst_flash_seq i_burst_flash_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .load_n(load_n), .adv_n(adv_n),
        .addr_in(addr_in), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .dout(dout), .dout_valid(dout_valid), .last_n(last_n),
        .burst_mode(burst_mode)
    );

    function automatic logic [DW-1:0] fdat(input logic [AW-1:0] a);
        return a[15:0] ^ {a[18:16], 13'h0A5};
    endfunction

    function automatic logic [AW-1:0] win(input logic [AW-1:0] a, input int k);
        return {a[AW-1:5], 5'(a[4:0] + k)};
    endfunction

    // Synchronous array model.
    always @(posedge clk) mem_rdata <= fdat(mem_addr);

    // Monitor: compare queued expectations for this edge.
    always @(posedge clk) begin
        cyc = cyc + 1;
        #2;
        while (q.size() > 0 && q[0].tgt == cyc) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (dout_valid !== e.v || dout !== e.d || last_n !== e.l || burst_mode !== e.m) begin
                errors++;
                $display("FAIL %s: got valid=%b dout=%h last_n=%b mode=%b, expected valid=%b dout=%h last_n=%b mode=%b",
                         e.req, dout_valid, dout, last_n, burst_mode, e.v, e.d, e.l, e.m);
            end
        end
    end

    task automatic exp_step(input logic v, input logic [DW-1:0] d, input logic l,
                            input logic m, input string req);
        exp_t e;
        e.tgt = cyc + 1; e.v = v; e.d = d; e.l = l; e.m = m; e.req = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic m, input string req);
        wr_addr = a; wr_data = d; wr_en = 1'b1; ce_n = 1'b0; oe_n = 1'b1; load_n = 1'b1;
        exp_step(1'b0, '0, 1'b1, m, req);
        wr_en = 1'b0;
    endtask

    task automatic cmd_seq(input logic [DW-1:0] d4, input logic m0, input logic m1,
                           input string req);
        wr_cmd(A1, K1, m0, req);
        wr_cmd(A2, K2, m0, req);
        wr_cmd(A1, K3, m0, req);
        wr_cmd(A1, d4, m1, req);
    endtask

    task automatic burst_start(input logic [AW-1:0] a, input string req);
        ce_n = 1'b0; oe_n = 1'b0; adv_n = 1'b1; load_n = 1'b0; addr_in = a;
        exp_step(1'b0, '0, 1'b1, 1'b1, req);
        load_n = 1'b1; addr_in = ~a;
        repeat (LAT - 1) exp_step(1'b0, '0, 1'b1, 1'b1, req);
        exp_step(1'b1, fdat(a), 1'b1, 1'b1, req);
    endtask

    task automatic advance(input logic [AW-1:0] a, input int k0, input int k1,
                           input string req);
        adv_n = 1'b0;
        for (int k = k0; k <= k1; k++)
            exp_step(1'b1, fdat(win(a, k)), (k != 31), 1'b1, req);
        adv_n = 1'b1;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got timeout, expected end of stimulus");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Stimulus.
    initial begin
        rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; wr_en = 1'b0; load_n = 1'b1;
        adv_n = 1'b1; addr_in = '0; wr_addr = '0; wr_data = '0;
        repeat (3) exp_step(1'b0, '0, 1'b1, 1'b0, "R1 reset");
        rst_n = 1'b1;
        exp_step(1'b0, '0, 1'b1, 1'b0, "R1 after reset");

        // R2: asynchronous reads
        ce_n = 1'b0; oe_n = 1'b0;
        addr_in = 19'h00000; exp_step(1'b1, fdat(19'h00000), 1'b1, 1'b0, "R2 low");
        addr_in = 19'h7FFFF; exp_step(1'b1, fdat(19'h7FFFF), 1'b1, 1'b0, "R2 high");
        addr_in = 19'h2A5A5; load_n = 1'b0;
        exp_step(1'b1, fdat(19'h2A5A5), 1'b1, 1'b0, "R2 load ignored");
        load_n = 1'b1;

        // R10: gating in asynchronous mode
        oe_n = 1'b1; exp_step(1'b0, '0, 1'b1, 1'b0, "R10 oe high");
        oe_n = 1'b0; ce_n = 1'b1; exp_step(1'b0, '0, 1'b1, 1'b0, "R10 ce high");
        ce_n = 1'b0;

        // R4: broken sequences leave the mode off
        wr_cmd(A1, K1, 1'b0, "R4");
        wr_cmd(A2, 16'h0056, 1'b0, "R4 bad data");
        wr_cmd(A1, K3, 1'b0, "R4");
        wr_cmd(A1, KEN, 1'b0, "R4 no enable");
        wr_cmd(A1, K1, 1'b0, "R4");
        wr_cmd(A1, K2, 1'b0, "R4 bad addr");
        wr_cmd(A1, K3, 1'b0, "R4");
        wr_cmd(A1, KEN, 1'b0, "R4 no enable");
        wr_cmd(A1, K1, 1'b0, "R5");
        wr_cmd(A2, K2, 1'b0, "R5");
        wr_cmd(19'h1234, KSW, 1'b0, "R5 soft reset mid-sequence");
        wr_cmd(A1, K3, 1'b0, "R5");
        wr_cmd(A1, KEN, 1'b0, "R5 sequence restarted");

        // R3: enable
        cmd_seq(KEN, 1'b0, 1'b1, "R3 enable");
        // R5: soft reset keeps the mode
        wr_cmd(19'h0, KSW, 1'b1, "R5 soft reset");

        // R6..R9: full burst starting mid-window
        burst_start(19'h2B3CD, "R6 first word");
        advance(19'h2B3CD, 1, 9, "R7 step");
        exp_step(1'b1, fdat(win(19'h2B3CD, 9)), 1'b1, 1'b1, "R8 hold");
        exp_step(1'b1, fdat(win(19'h2B3CD, 9)), 1'b1, 1'b1, "R8 hold");
        advance(19'h2B3CD, 10, 30, "R7 wrap");
        advance(19'h2B3CD, 31, 31, "R9 last word");
        adv_n = 1'b0;
        exp_step(1'b0, '0, 1'b1, 1'b1, "R9 burst end");
        adv_n = 1'b1;

        // R6: double load strobe reloads
        ce_n = 1'b0; oe_n = 1'b0; load_n = 1'b0; addr_in = 19'h11111;
        exp_step(1'b0, '0, 1'b1, 1'b1, "R6 first load");
        burst_start(19'h4567F, "R6 reload");
        advance(19'h4567F, 1, 2, "R7 wrap at start");

        // R10: gating in burst keeps the position
        oe_n = 1'b1; exp_step(1'b0, '0, 1'b1, 1'b1, "R10 burst oe high");
        oe_n = 1'b0; exp_step(1'b1, fdat(win(19'h4567F, 2)), 1'b1, 1'b1, "R10 resume");
        ce_n = 1'b1; load_n = 1'b0; addr_in = 19'h00020;
        exp_step(1'b0, '0, 1'b1, 1'b1, "R10 load ignored");
        ce_n = 1'b0; load_n = 1'b1;
        exp_step(1'b1, fdat(win(19'h4567F, 2)), 1'b1, 1'b1, "R10 position kept");

        // R11: abort by new load
        burst_start(19'h7FFE0, "R11 abort restart");
        advance(19'h7FFE0, 1, 1, "R11 step");

        // R3: disable, then asynchronous read again
        cmd_seq(KDIS, 1'b1, 1'b0, "R3 disable");
        ce_n = 1'b0; oe_n = 1'b0; addr_in = 19'h0ABCD;
        exp_step(1'b1, fdat(19'h0ABCD), 1'b1, 1'b0, "R2 after disable");

        // R5: hardware reset clears the mode
        cmd_seq(KEN, 1'b0, 1'b1, "R3 enable again");
        rst_n = 1'b0;
        exp_step(1'b0, '0, 1'b1, 1'b0, "R5 hardware reset");
        rst_n = 1'b1;
        exp_step(1'b0, '0, 1'b1, 1'b0, "R1 mode stays off");

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule